// File: doc/BRIEF.md
# Grouped Two-Level Interrupt Expander

The expander collects 96 raw interrupt lines, arranged as 12 groups of 8 sources, and presents one interrupt request to a processor core. In the first level, each group latches the rising edges of its lines into a flag register and qualifies them with a per-source enable. Among its enabled pending sources it picks the lowest-numbered one, and it forwards one request to the core level through a per-group acknowledge gate. After a group forwards, it stays silent until software clears its acknowledge bit.

The second level holds one flag bit and one enable bit per group, plus a global mask. When the mask is clear and an enabled core flag is set, the request output is high. The vector index output then names the winning source as group*8 + source, with groups and sources numbered from zero. When the core takes the interrupt, the winning source's group flag and the group's core flag clear together. A separate trap port converts a software trap number into the vector of the first source of the matching group. Trap numbers with no such group produce an error pulse.

Software reaches every register through a single-cycle write port and a combinational read port.

Top module: `irq_expander`

## Requirements
- R1: A rising edge on raw line g*8+s sets bit s of the flag register of group g, which is read at address 0x10+g. A line that stays high does not set the flag again after the flag is cleared.
- R2: The enable register of group g is at address 0x00+g. A flagged source whose enable bit is 0 forwards nothing: the core flag, the acknowledge bit and irq_o stay 0 until the enable bit is set.
- R3: Inside a group, the lowest-numbered pending enabled source wins. Across groups, the lowest-numbered active group wins. vec_o = group*8 + source, zero-based.
- R4: When a group forwards a request, bit g of the core flag (0x20) and bit g of the acknowledge register (0x23) are set on the next clock edge. While the acknowledge bit is set, the group forwards nothing more. Writing 1 to that bit clears it, and a source still pending forwards on the next cycle.
- R5: irq_o is 1 exactly when some group has both its core flag and its core enable (0x21) set, and the global mask (bit 0 of 0x22, reset value 1) is 0.
- R6: A take_i pulse while irq_o is 1 clears, on that clock edge, the winning source's group flag and the winning group's core flag. While irq_o is 0, take_i has no effect on any flag.
- R7: Writing 1 to a bit of a group flag register or of the core flag register clears that bit. If a set event and a clear request hit the same bit in the same cycle, the set wins.
- R8: A trap request with number n in 1..12 produces trap_vld_o = 1 one cycle later, with trap_vec_o = (n-1)*8.
- R9: A trap request with number 0, or with a number above 12, produces trap_err_o = 1 one cycle later, with trap_vld_o = 0 and trap_vec_o = 0.
- R10: After reset, all flag, enable and acknowledge registers are 0, the global mask is 1, and irq_o, vec_o and every trap output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 96 | Raw interrupt lines, line g*8+s |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 6 | Register address |
| reg_wdata_i | input | 12 | Register write data |
| reg_rdata_o | output | 12 | Register read data at reg_addr_i |
| take_i | input | 1 | The core accepts the current interrupt |
| trap_req_i | input | 1 | Software trap request |
| trap_num_i | input | 4 | Trap number |
| irq_o | output | 1 | Interrupt request to the core |
| vec_o | output | 7 | Vector index of the winning source |
| trap_vld_o | output | 1 | Trap vector valid |
| trap_err_o | output | 1 | Illegal trap number |
| trap_vec_o | output | 7 | Trap vector index |

## Verification
The hardest state to reach is a group whose acknowledge bit is set while further sources in it are still flagged and enabled. In that state the pending work must stay invisible at the ports until software clears the bit, and it must then come out one source at a time in priority order. The stimulus raises three lines of one group in the same cycle, takes the first interrupt, and holds for several cycles while checking that no request appears and that the flag register still shows the other two sources. It then clears the acknowledge bit repeatedly and checks each vector in turn. A full sweep over all 96 lines, a two-group collision and a same-cycle set/clear race cover the remaining orderings.

// File: rtl/irq_exp_pkg.sv
package irq_exp_pkg;
  localparam int unsigned GRP_N_DEF = 12;
  localparam int unsigned SRC_N_DEF = 8;
  localparam int unsigned ADDR_W    = 6;

  localparam logic [ADDR_W-1:0] A_GEN_BASE  = 6'h00;
  localparam logic [ADDR_W-1:0] A_GFLG_BASE = 6'h10;
  localparam logic [ADDR_W-1:0] A_CFLAG     = 6'h20;
  localparam logic [ADDR_W-1:0] A_CEN       = 6'h21;
  localparam logic [ADDR_W-1:0] A_GMASK     = 6'h22;
  localparam logic [ADDR_W-1:0] A_ACK       = 6'h23;
endpackage

// File: rtl/irq_exp_grp.sv
module irq_exp_grp #(
  parameter int unsigned SRC_N = 8,
  localparam int unsigned SRC_W = $clog2(SRC_N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SRC_N-1:0] raw_i,
  input  logic             en_we_i,
  input  logic             flag_we_i,
  input  logic             ack_clr_i,
  input  logic [SRC_N-1:0] wdata_i,
  input  logic             take_i,
  output logic [SRC_N-1:0] en_o,
  output logic [SRC_N-1:0] flag_o,
  output logic             ack_o,
  output logic             fwd_o,
  output logic [SRC_W-1:0] src_o
);
  logic [SRC_N-1:0] raw_q, flag_q, en_q;
  logic             ack_q;
  logic [SRC_N-1:0] hit, rise, take_mask, wclr;

  assign hit  = flag_q & en_q;
  assign rise = raw_i & ~raw_q;
  assign wclr = flag_we_i ? wdata_i : '0;

  // lowest index wins
  always_comb begin
    src_o = '0;
    for (int i = SRC_N - 1; i >= 0; i--)
      if (hit[i]) src_o = SRC_W'(i);
  end

  always_comb begin
    for (int i = 0; i < SRC_N; i++)
      take_mask[i] = take_i && (src_o == SRC_W'(i));
  end

  assign fwd_o  = (|hit) & ~ack_q;
  assign en_o   = en_q;
  assign flag_o = flag_q;
  assign ack_o  = ack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q  <= '0;
      flag_q <= '0;
      en_q   <= '0;
      ack_q  <= 1'b0;
    end else begin
      raw_q  <= raw_i;
      flag_q <= (flag_q & ~wclr & ~take_mask) | rise;
      if (en_we_i) en_q <= wdata_i;
      ack_q  <= (ack_q & ~ack_clr_i) | fwd_o;
    end
  end
endmodule

// File: rtl/irq_exp_core.sv
module irq_exp_core #(
  parameter int unsigned GRP_N = 12,
  parameter int unsigned SRC_N = 8,
  localparam int unsigned GRP_W = $clog2(GRP_N),
  localparam int unsigned SRC_W = $clog2(SRC_N),
  localparam int unsigned VEC_W = $clog2(GRP_N * SRC_N)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [GRP_N-1:0]       fwd_i,
  input  logic                   cflag_we_i,
  input  logic                   cen_we_i,
  input  logic                   gmask_we_i,
  input  logic [GRP_N-1:0]       wdata_i,
  input  logic                   take_i,
  input  logic [GRP_N*SRC_W-1:0] src_i,
  output logic [GRP_N-1:0]       cflag_o,
  output logic [GRP_N-1:0]       cen_o,
  output logic                   gmask_o,
  output logic                   irq_o,
  output logic [GRP_W-1:0]       grp_o,
  output logic [VEC_W-1:0]       vec_o,
  output logic [GRP_N-1:0]       grp_take_o
);
  logic [GRP_N-1:0] cflag_q, cen_q, act, wclr;
  logic             gmask_q;
  logic [SRC_W-1:0] sel_src;

  assign act  = cflag_q & cen_q;
  assign wclr = cflag_we_i ? wdata_i : '0;

  always_comb begin
    grp_o = '0;
    for (int i = GRP_N - 1; i >= 0; i--)
      if (act[i]) grp_o = GRP_W'(i);
  end

  assign sel_src = src_i[grp_o*SRC_W +: SRC_W];
  assign irq_o   = (|act) & ~gmask_q;
  assign vec_o   = irq_o ? (VEC_W'(grp_o) * VEC_W'(SRC_N) + VEC_W'(sel_src)) : '0;

  always_comb begin
    for (int i = 0; i < GRP_N; i++)
      grp_take_o[i] = take_i && irq_o && (grp_o == GRP_W'(i));
  end

  assign cflag_o = cflag_q;
  assign cen_o   = cen_q;
  assign gmask_o = gmask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cflag_q <= '0;
      cen_q   <= '0;
      gmask_q <= 1'b1;
    end else begin
      cflag_q <= (cflag_q & ~wclr & ~grp_take_o) | fwd_i;
      if (cen_we_i)   cen_q   <= wdata_i;
      if (gmask_we_i) gmask_q <= wdata_i[0];
    end
  end
endmodule

// File: rtl/irq_exp_trap.sv
module irq_exp_trap #(
  parameter int unsigned GRP_N = 12,
  parameter int unsigned SRC_N = 8,
  localparam int unsigned TRAP_W = $clog2(GRP_N + 1),
  localparam int unsigned VEC_W  = $clog2(GRP_N * SRC_N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trap_req_i,
  input  logic [TRAP_W-1:0] trap_num_i,
  output logic              trap_vld_o,
  output logic              trap_err_o,
  output logic [VEC_W-1:0]  trap_vec_o
);
  logic             legal;
  logic [VEC_W-1:0] vec;

  assign legal = (trap_num_i != '0) && (int'(trap_num_i) <= GRP_N);
  assign vec   = (VEC_W'(trap_num_i) - VEC_W'(1)) * VEC_W'(SRC_N);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trap_vld_o <= 1'b0;
      trap_err_o <= 1'b0;
      trap_vec_o <= '0;
    end else begin
      trap_vld_o <= trap_req_i & legal;
      trap_err_o <= trap_req_i & ~legal;
      trap_vec_o <= (trap_req_i & legal) ? vec : '0;
    end
  end
endmodule

// File: rtl/irq_expander.sv
module irq_expander
  import irq_exp_pkg::*;
#(
  parameter int unsigned GRP_N = GRP_N_DEF,
  parameter int unsigned SRC_N = SRC_N_DEF,
  localparam int unsigned LINE_N = GRP_N * SRC_N,
  localparam int unsigned DATA_W = (GRP_N > SRC_N) ? GRP_N : SRC_N,
  localparam int unsigned TRAP_W = $clog2(GRP_N + 1),
  localparam int unsigned VEC_W  = $clog2(LINE_N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LINE_N-1:0] irq_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              take_i,
  input  logic              trap_req_i,
  input  logic [TRAP_W-1:0] trap_num_i,
  output logic              irq_o,
  output logic [VEC_W-1:0]  vec_o,
  output logic              trap_vld_o,
  output logic              trap_err_o,
  output logic [VEC_W-1:0]  trap_vec_o
);
  localparam int unsigned SRC_W = $clog2(SRC_N);
  localparam int unsigned GRP_W = $clog2(GRP_N);

  logic [SRC_N-1:0]       en_a   [GRP_N];
  logic [SRC_N-1:0]       flag_a [GRP_N];
  logic [GRP_N-1:0]       ack_w, fwd_w, grp_take_w, cflag_w, cen_w;
  logic [GRP_N*SRC_W-1:0] src_w;
  logic [GRP_W-1:0]       grp_w;
  logic                   gmask_w;
  logic                   ack_we;

  assign ack_we = reg_we_i && (reg_addr_i == A_ACK);

  for (genvar g = 0; g < GRP_N; g++) begin : gen_grp
    logic en_we, flag_we;
    assign en_we   = reg_we_i && (reg_addr_i == A_GEN_BASE + ADDR_W'(g));
    assign flag_we = reg_we_i && (reg_addr_i == A_GFLG_BASE + ADDR_W'(g));

    irq_exp_grp #(.SRC_N(SRC_N)) i_grp (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .raw_i     (irq_i[g*SRC_N +: SRC_N]),
      .en_we_i   (en_we),
      .flag_we_i (flag_we),
      .ack_clr_i (ack_we & reg_wdata_i[g]),
      .wdata_i   (reg_wdata_i[SRC_N-1:0]),
      .take_i    (grp_take_w[g]),
      .en_o      (en_a[g]),
      .flag_o    (flag_a[g]),
      .ack_o     (ack_w[g]),
      .fwd_o     (fwd_w[g]),
      .src_o     (src_w[g*SRC_W +: SRC_W])
    );
  end

  irq_exp_core #(.GRP_N(GRP_N), .SRC_N(SRC_N)) i_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fwd_i      (fwd_w),
    .cflag_we_i (reg_we_i && (reg_addr_i == A_CFLAG)),
    .cen_we_i   (reg_we_i && (reg_addr_i == A_CEN)),
    .gmask_we_i (reg_we_i && (reg_addr_i == A_GMASK)),
    .wdata_i    (reg_wdata_i[GRP_N-1:0]),
    .take_i     (take_i),
    .src_i      (src_w),
    .cflag_o    (cflag_w),
    .cen_o      (cen_w),
    .gmask_o    (gmask_w),
    .irq_o      (irq_o),
    .grp_o      (grp_w),
    .vec_o      (vec_o),
    .grp_take_o (grp_take_w)
  );

  irq_exp_trap #(.GRP_N(GRP_N), .SRC_N(SRC_N)) i_trap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .trap_req_i (trap_req_i),
    .trap_num_i (trap_num_i),
    .trap_vld_o (trap_vld_o),
    .trap_err_o (trap_err_o),
    .trap_vec_o (trap_vec_o)
  );

  // read mux; group registers decode on the low nibble
  always_comb begin
    int idx;
    idx = int'(reg_addr_i[3:0]);
    reg_rdata_o = '0;
    if (reg_addr_i[5:4] == 2'b00 && idx < GRP_N)
      reg_rdata_o = DATA_W'(en_a[idx]);
    else if (reg_addr_i[5:4] == 2'b01 && idx < GRP_N)
      reg_rdata_o = DATA_W'(flag_a[idx]);
    else if (reg_addr_i == A_CFLAG)
      reg_rdata_o = DATA_W'(cflag_w);
    else if (reg_addr_i == A_CEN)
      reg_rdata_o = DATA_W'(cen_w);
    else if (reg_addr_i == A_GMASK)
      reg_rdata_o = DATA_W'(gmask_w);
    else if (reg_addr_i == A_ACK)
      reg_rdata_o = DATA_W'(ack_w);
  end
endmodule

// File: rtl/irq_exp_chk.sv
module irq_exp_chk #(
  parameter int unsigned GRP_N  = 12,
  parameter int unsigned SRC_N  = 8,
  parameter int unsigned GRP_W  = 4,
  parameter int unsigned TRAP_W = 4,
  parameter int unsigned VEC_W  = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              irq_o,
  input logic              take_i,
  input logic [GRP_W-1:0]  grp_i,
  input logic [GRP_N-1:0]  cflag_i,
  input logic [GRP_N-1:0]  cen_i,
  input logic              gmask_i,
  input logic [GRP_N-1:0]  ack_i,
  input logic [GRP_N-1:0]  fwd_i,
  input logic [GRP_N-1:0]  grp_take_i,
  input logic              trap_req_i,
  input logic [TRAP_W-1:0] trap_num_i,
  input logic              trap_vld_o,
  input logic              trap_err_o,
  input logic [VEC_W-1:0]  trap_vec_o
);
  p_mask_gate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gmask_i |-> !irq_o);

  p_irq_source_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (cflag_i[grp_i] && cen_i[grp_i]));

  p_fwd_sets_ack_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|fwd_i) |=> ((ack_i & $past(fwd_i)) == $past(fwd_i)));

  p_take_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && take_i && !fwd_i[grp_i]) |=> !cflag_i[$past(grp_i)]);

  p_take_gated_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grp_take_i) && (irq_o || grp_take_i == '0));

  p_trap_legal_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_vld_o |-> (!trap_err_o && (int'(trap_vec_o) % SRC_N == 0)));

  p_trap_first_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_req_i && trap_num_i == TRAP_W'(1)) |=> (trap_vld_o && trap_vec_o == '0));

  p_trap_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_req_i && trap_num_i == '0) |=> (trap_err_o && !trap_vld_o));
endmodule

bind irq_expander irq_exp_chk #(
  .GRP_N(GRP_N), .SRC_N(SRC_N), .GRP_W($clog2(GRP_N)),
  .TRAP_W($clog2(GRP_N + 1)), .VEC_W($clog2(GRP_N * SRC_N))
) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .irq_o      (irq_o),
  .take_i     (take_i),
  .grp_i      (grp_w),
  .cflag_i    (cflag_w),
  .cen_i      (cen_w),
  .gmask_i    (gmask_w),
  .ack_i      (ack_w),
  .fwd_i      (fwd_w),
  .grp_take_i (grp_take_w),
  .trap_req_i (trap_req_i),
  .trap_num_i (trap_num_i),
  .trap_vld_o (trap_vld_o),
  .trap_err_o (trap_err_o),
  .trap_vec_o (trap_vec_o)
);

// File: tb/test_irq_expander.sv
module test_irq_expander;
  localparam int GN = 12;
  localparam int SN = 8;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [95:0] irq = '0;
  logic        reg_we = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [11:0] reg_wdata = '0;
  logic [11:0] reg_rdata;
  logic        take = 1'b0;
  logic        trap_req = 1'b0;
  logic [3:0]  trap_num = '0;
  logic        irq_o, trap_vld, trap_err;
  logic [6:0]  vec, trap_vec;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_expander i_irq_expander (
    .clk_i(clk), .rst_ni(rst_ni), .irq_i(irq), .reg_we_i(reg_we),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .take_i(take), .trap_req_i(trap_req), .trap_num_i(trap_num),
    .irq_o(irq_o), .vec_o(vec), .trap_vld_o(trap_vld), .trap_err_o(trap_err),
    .trap_vec_o(trap_vec)
  );

  task automatic step();
    @(posedge clk);
    #5;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    reg_we = 1'b1; reg_addr = 6'(a); reg_wdata = 12'(d);
    step();
    reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    reg_addr = 6'(a);
    #1;
    v = int'(reg_rdata);
  endtask

  task automatic take_one();
    take = 1'b1;
    step();
    take = 1'b0;
  endtask

  initial begin
    int v;
    step(); step();
    rst_ni = 1'b1;
    step();
    // R10 reset state
    chk("R10 irq", int'(irq_o), 0);
    chk("R10 vec", int'(vec), 0);
    chk("R10 trap", int'({trap_vld, trap_err}), 0);
    rd(6'h22, v); chk("R10 gmask", v, 1);
    rd(6'h21, v); chk("R10 cen", v, 0);
    rd(6'h23, v); chk("R10 ack", v, 0);
    for (int g = 0; g < GN; g++) begin
      rd(g, v);        chk("R10 gen", v, 0);
      rd(16 + g, v);   chk("R10 gflag", v, 0);
    end

    for (int g = 0; g < GN; g++) wr(g, 8'hFF);
    wr(6'h21, 12'hFFF);
    wr(6'h22, 0);

    // R1 R3 R4 R6 full sweep
    for (int g = 0; g < GN; g++)
      for (int s = 0; s < SN; s++) begin
        irq[g*SN+s] = 1'b1;
        step(); step();
        chk("R3 sweep irq", int'(irq_o), 1);
        chk("R3 sweep vec", int'(vec), g*SN + s);
        rd(6'h23, v); chk("R4 sweep ack", (v >> g) & 1, 1);
        take_one();
        chk("R6 sweep irq after take", int'(irq_o), 0);
        rd(16 + g, v); chk("R6 sweep gflag", v, 0);
        wr(6'h23, 1 << g);
        irq[g*SN+s] = 1'b0;
      end

    // R1 steady high does not re-set
    irq[0] = 1'b1;
    step(); step();
    take_one();
    wr(6'h23, 1);
    step(); step();
    chk("R1 level hold irq", int'(irq_o), 0);
    rd(16, v); chk("R1 level hold gflag", v, 0);
    irq[0] = 1'b0;

    // R3 R4 simultaneous in group 3, ack stall
    irq[3*SN+2] = 1'b1; irq[3*SN+5] = 1'b1; irq[3*SN+7] = 1'b1;
    step(); step();
    chk("R3 simul vec", int'(vec), 26);
    take_one();
    for (int k = 0; k < 3; k++) begin
      chk("R4 stall irq", int'(irq_o), 0);
      step();
    end
    rd(16 + 3, v); chk("R4 stall gflag", v, 8'hA0);
    wr(6'h23, 1 << 3);
    step();
    chk("R4 release irq", int'(irq_o), 1);
    chk("R3 second vec", int'(vec), 29);
    take_one();
    wr(6'h23, 1 << 3);
    step();
    chk("R3 third vec", int'(vec), 31);
    take_one();
    wr(6'h23, 1 << 3);
    step();
    chk("R4 drained irq", int'(irq_o), 0);
    irq[3*SN+2] = 1'b0; irq[3*SN+5] = 1'b0; irq[3*SN+7] = 1'b0;

    // R3 across groups
    irq[9*SN+4] = 1'b1; irq[1*SN+0] = 1'b1;
    step(); step();
    chk("R3 cross vec first", int'(vec), 8);
    take_one();
    chk("R3 cross irq", int'(irq_o), 1);
    chk("R3 cross vec second", int'(vec), 76);
    take_one();
    chk("R3 cross done", int'(irq_o), 0);
    wr(6'h23, 12'h202);
    irq[9*SN+4] = 1'b0; irq[1*SN+0] = 1'b0;

    // R5 global mask, R6 take ignored
    wr(6'h22, 1);
    irq[5*SN+1] = 1'b1;
    step(); step();
    chk("R5 masked irq", int'(irq_o), 0);
    rd(6'h20, v); chk("R5 masked cflag", (v >> 5) & 1, 1);
    take_one();
    rd(6'h20, v); chk("R6 ignored cflag", (v >> 5) & 1, 1);
    rd(16 + 5, v); chk("R6 ignored gflag", v, 2);
    wr(6'h22, 0);
    chk("R5 unmask irq", int'(irq_o), 1);
    chk("R5 unmask vec", int'(vec), 41);
    take_one();
    wr(6'h23, 1 << 5);
    irq[5*SN+1] = 1'b0;

    // R5 core enable
    wr(6'h21, 12'hFFF & ~(1 << 6));
    irq[6*SN+3] = 1'b1;
    step(); step();
    chk("R5 cen off irq", int'(irq_o), 0);
    rd(6'h20, v); chk("R5 cen off cflag", (v >> 6) & 1, 1);
    wr(6'h21, 12'hFFF);
    chk("R5 cen on vec", int'(vec), 51);
    take_one();
    wr(6'h23, 1 << 6);
    irq[6*SN+3] = 1'b0;

    // R2 group enable
    wr(7, 8'hFE);
    irq[7*SN] = 1'b1;
    step(); step();
    chk("R2 disabled irq", int'(irq_o), 0);
    rd(16 + 7, v); chk("R2 disabled gflag", v, 1);
    rd(6'h20, v); chk("R2 disabled cflag", (v >> 7) & 1, 0);
    rd(6'h23, v); chk("R2 disabled ack", (v >> 7) & 1, 0);
    wr(7, 8'hFF);
    step();
    chk("R2 enabled irq", int'(irq_o), 1);
    chk("R2 enabled vec", int'(vec), 56);
    take_one();
    wr(6'h23, 1 << 7);
    irq[7*SN] = 1'b0;

    // R7 write-one-to-clear, set beats clear
    wr(2, 0);
    irq[2*SN+1] = 1'b1; irq[2*SN+3] = 1'b1;
    step();
    irq[2*SN+1] = 1'b0;
    step();
    rd(16 + 2, v); chk("R7 before clear", v, 8'h0A);
    irq[2*SN+1] = 1'b1;
    wr(16 + 2, 8'h0A);
    rd(16 + 2, v); chk("R7 set wins", v, 8'h02);
    wr(16 + 2, 8'hFF);
    rd(16 + 2, v); chk("R7 cleared", v, 0);
    irq[2*SN+1] = 1'b0; irq[2*SN+3] = 1'b0;
    wr(2, 8'hFF);

    // R8 R9 trap sweep
    for (int n = 0; n < 16; n++) begin
      bit ok;
      ok = (n >= 1) && (n <= GN);
      trap_req = 1'b1; trap_num = 4'(n);
      step();
      trap_req = 1'b0;
      chk(ok ? "R8 trap vld" : "R9 trap vld", int'(trap_vld), ok ? 1 : 0);
      chk(ok ? "R8 trap err" : "R9 trap err", int'(trap_err), ok ? 0 : 1);
      chk(ok ? "R8 trap vec" : "R9 trap vec", int'(trap_vec), ok ? (n - 1) * SN : 0);
      step();
      chk("R8 trap idle", int'({trap_vld, trap_err}), 0);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual 1 expected 0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule